// File: doc/BRIEF.md
# Serial Sampling Converter Capture Controller

This block sits on the host side of a 12-bit serial sampling converter. It drives the converter's conversion-start strobe and serial clock and collects the serial word the converter returns. When a request arrives, the block raises the strobe for one phase, which holds the input and starts a conversion. It then runs a burst of 16 serial clock pulses. On the clock edge that ends each high phase it samples the data line, which is the edge opposite the one the converter uses to change the line. From the burst it keeps one status bit (the reference-ready flag) and the twelve data bits after it, most significant bit first.

The converter returns the sample taken at the previous conversion start. The first word after reset therefore carries no meaningful sample, and the block drops it. Every later word appears on a parallel output together with its reference-ready flag and a one-cycle valid strobe. The block can also put the converter into its two low-power states. It does this by issuing two or four strobe pulses while the serial clock stays low. It wakes the converter with a single serial clock pulse.

The phase length is set at run time. Each phase of the strobe or the serial clock lasts `div_half + 1` system clock cycles. In this brief that length is called L.

Top module: `sadc_capture_ctrl`

## Requirements
- R1: While reset is held and in the cycle after it is released, conv, sck, busy, result_valid and ref_ready are 0 and result is 0.
- R2: A request with cmd_op = 2'b00 (convert), accepted while idle, raises conv in the next cycle for exactly L cycles. sck then stays low for L more cycles. After that come 16 sck pulses, each L cycles high followed by L cycles low. L equals div_half + 1, and div_half is held constant while busy.
- R3: sdata is sampled in the cycle that ends each sck high phase. The sample from pulse 3 becomes ref_ready. The samples from pulses 4 through 15 become result bits 11 down to 0 in that order. The samples from pulses 1, 2 and 16 are ignored.
- R4: result_valid is high for exactly one cycle, 33·L cycles after conv first reads high. result and ref_ready change only in that cycle and otherwise hold their last values.
- R5: The first conversion completed after reset produces no result_valid pulse and leaves result and ref_ready at 0.
- R6: busy rises in the same cycle as the first conv or sck edge of a command. It stays high for 34·L cycles for a convert, 4·L for nap, 8·L for sleep and 2·L for wake. conv and sck are low whenever busy is low.
- R7: A request presented while busy is ignored. The running command's pulse counts, busy length and result are the same as without the request.
- R8: cmd_op = 2'b01 (nap) issues two conv pulses, each L cycles high and L cycles low, with sck held low throughout.
- R9: cmd_op = 2'b10 (sleep) issues four conv pulses of the same shape, with sck held low throughout.
- R10: cmd_op = 2'b11 (wake) issues one sck pulse, L cycles high and L cycles low, with conv held low.
- R11: conv and sck are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_half | input | DIV_W (8) | Phase length minus one, in system clock cycles |
| cmd_valid | input | 1 | Command request, taken only while idle |
| cmd_op | input | 2 | Command code: 00 convert, 01 nap, 10 sleep, 11 wake |
| sdata | input | 1 | Serial data line from the converter |
| conv | output | 1 | Conversion-start strobe to the converter |
| sck | output | 1 | Serial clock to the converter |
| busy | output | 1 | A command sequence is in progress |
| result | output | DATA_W (12) | Last captured conversion word |
| ref_ready | output | 1 | Reference-ready status bit of the last word |
| result_valid | output | 1 | One-cycle strobe marking a new result |

## Verification
The assertions assume a few things about the inputs. div_half does not change while busy is high. Reset is held low from time zero until after the first clock edge. sdata may take any value, so none of the properties depends on it.

The bench changes div_half only between commands, and always after busy has fallen. It applies reset at the start of each divider setting. A small converter model drives sdata: on each sck rising edge it presents the next bit of a word that the bench chose before the command, and it puts junk on the bit positions that must be ignored. The expected results come from that chosen word.

// File: rtl/sadc_pkg.sv
// Package: shared types for the serial converter capture controller.
// Assumes nothing beyond being compiled before the modules that import it.
package sadc_pkg;

    // Command codes as seen on cmd_op
    typedef enum logic [1:0] {
        OP_CONVERT = 2'b00,
        OP_NAP     = 2'b01,
        OP_SLEEP   = 2'b10,
        OP_WAKE    = 2'b11
    } sadc_op_e;

    // Sequencer phases: strobe high/low and serial clock high/low
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_CONV_HI = 3'd1,
        ST_CONV_LO = 3'd2,
        ST_SCK_HI  = 3'd3,
        ST_SCK_LO  = 3'd4
    } sadc_state_e;

endpackage

// File: rtl/sadc_phase_timer.sv
// Phase timer: while run is high, produces phase_end once every
// div_half+1 cycles. Restarts from zero whenever run is low.
// Assumes div_half is stable while run is high.
module sadc_phase_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_half,
    output logic             phase_end
);

    logic [DIV_W-1:0] cnt_q;

    assign phase_end = run && (cnt_q == div_half);

    // Count cycles within the current phase
    always_ff @(posedge clk) begin
        if (!rst_n || !run || phase_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sadc_sequencer.sv
// Sequencer: accepts a command while idle and walks the strobe and
// serial clock phases for convert, nap, sleep and wake. Outputs are
// registered from the next state, so conv and sck are glitch free.
// It flags which high-phase ends carry a bit worth keeping.
// Assumes phase_end comes from a timer that runs whenever busy is high.
module sadc_sequencer
    import sadc_pkg::*;
#(
    parameter int NUM_SCK      = 16,
    parameter int LEAD         = 2,
    parameter int DATA_W       = 12,
    parameter int NAP_PULSES   = 2,
    parameter int SLEEP_PULSES = 4,
    parameter int WAKE_PULSES  = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic       phase_end,
    output logic       busy,
    output logic       conv,
    output logic       sck,
    output logic       keep,
    output logic       last
);

    localparam int MAX_A  = (NUM_SCK > SLEEP_PULSES) ? NUM_SCK : SLEEP_PULSES;
    localparam int MAX_B  = (NAP_PULSES > WAKE_PULSES) ? NAP_PULSES : WAKE_PULSES;
    localparam int MAX_P  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W  = $clog2(MAX_P + 1);
    localparam int WIN_HI = LEAD + DATA_W;

    sadc_state_e      state_q, state_d;
    sadc_op_e         op_q, op_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] target;
    logic             conv_q, sck_q;
    logic             sample;

    // Pulse count that ends the running command
    always_comb begin
        case (op_q)
            OP_CONVERT: target = CNT_W'(NUM_SCK);
            OP_NAP:     target = CNT_W'(NAP_PULSES);
            OP_SLEEP:   target = CNT_W'(SLEEP_PULSES);
            default:    target = CNT_W'(WAKE_PULSES);
        endcase
    end

    // Next-state logic for the phase walk
    always_comb begin
        state_d = state_q;
        op_d    = op_q;
        cnt_d   = cnt_q;
        case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    op_d    = sadc_op_e'(cmd_op);
                    cnt_d   = '0;
                    state_d = (sadc_op_e'(cmd_op) == OP_WAKE) ? ST_SCK_HI : ST_CONV_HI;
                end
            end
            ST_CONV_HI: begin
                if (phase_end) begin
                    state_d = ST_CONV_LO;
                    cnt_d   = cnt_q + 1'b1;
                end
            end
            ST_CONV_LO: begin
                if (phase_end) begin
                    if (op_q == OP_CONVERT) begin
                        state_d = ST_SCK_HI;
                        cnt_d   = '0;
                    end else if (cnt_q == target) begin
                        state_d = ST_IDLE;
                    end else begin
                        state_d = ST_CONV_HI;
                    end
                end
            end
            ST_SCK_HI: begin
                if (phase_end) begin
                    state_d = ST_SCK_LO;
                    cnt_d   = cnt_q + 1'b1;
                end
            end
            ST_SCK_LO: begin
                if (phase_end) begin
                    state_d = (cnt_q == target) ? ST_IDLE : ST_SCK_HI;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State, command and pulse counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_CONVERT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            op_q    <= op_d;
            cnt_q   <= cnt_d;
        end
    end

    // Pin drivers registered from the next state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_q <= 1'b0;
            sck_q  <= 1'b0;
        end else begin
            conv_q <= (state_d == ST_CONV_HI);
            sck_q  <= (state_d == ST_SCK_HI);
        end
    end

    assign conv   = conv_q;
    assign sck    = sck_q;
    assign busy   = (state_q != ST_IDLE);
    assign sample = (state_q == ST_SCK_HI) && phase_end && (op_q == OP_CONVERT);
    assign keep   = sample && (cnt_q >= CNT_W'(LEAD)) && (cnt_q <= CNT_W'(WIN_HI));
    assign last   = sample && (cnt_q == CNT_W'(NUM_SCK - 1));

endmodule

// File: rtl/sadc_capture.sv
// Capture: shifts in the kept serial bits MSB first and, at the end of
// the burst, moves the word to the parallel outputs. The first burst
// after reset carries a stale sample and is dropped.
// Assumes keep and last come from the sequencer in burst order.
module sadc_capture #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              keep,
    input  logic              last,
    input  logic              sdata,
    output logic [DATA_W-1:0] result,
    output logic              ref_ready,
    output logic              result_valid
);

    localparam int WORD_W = DATA_W + 1;

    logic [WORD_W-1:0] shreg_q;
    logic [WORD_W-1:0] word_nx;
    logic              stale_q;

    assign word_nx = keep ? {shreg_q[WORD_W-2:0], sdata} : shreg_q;

    // Shift register for status plus data bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
        end else begin
            shreg_q <= word_nx;
        end
    end

    // Parallel outputs, stale-word drop and valid strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result       <= '0;
            ref_ready    <= 1'b0;
            result_valid <= 1'b0;
            stale_q      <= 1'b1;
        end else begin
            result_valid <= 1'b0;
            if (last) begin
                stale_q <= 1'b0;
                if (!stale_q) begin
                    ref_ready    <= word_nx[WORD_W-1];
                    result       <= word_nx[DATA_W-1:0];
                    result_valid <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sadc_capture_ctrl.sv
// Top: host-side controller for a serial sampling converter. Joins
// the phase timer, the sequencer and the capture path.
// Assumes div_half is changed only while busy is low.
module sadc_capture_ctrl #(
    parameter int DIV_W   = 8,
    parameter int DATA_W  = 12,
    parameter int NUM_SCK = 16,
    parameter int LEAD    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_half,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic              sdata,
    output logic              conv,
    output logic              sck,
    output logic              busy,
    output logic [DATA_W-1:0] result,
    output logic              ref_ready,
    output logic              result_valid
);

    localparam int TAIL = NUM_SCK - LEAD - DATA_W - 1;

    logic phase_end;
    logic keep;
    logic last;

    // Elaboration guard: the burst must hold the whole word
    if (TAIL < 0) begin : g_bad_burst
        initial $error("burst too short for status plus data bits");
    end

    sadc_phase_timer #(.DIV_W(DIV_W)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .div_half  (div_half),
        .phase_end (phase_end)
    );

    sadc_sequencer #(
        .NUM_SCK (NUM_SCK),
        .LEAD    (LEAD),
        .DATA_W  (DATA_W)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .phase_end (phase_end),
        .busy      (busy),
        .conv      (conv),
        .sck       (sck),
        .keep      (keep),
        .last      (last)
    );

    sadc_capture #(.DATA_W(DATA_W)) cap_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .keep         (keep),
        .last         (last),
        .sdata        (sdata),
        .result       (result),
        .ref_ready    (ref_ready),
        .result_valid (result_valid)
    );

endmodule

// File: rtl/sadc_capture_ctrl_chk.sv
// Checker: protocol properties of the capture controller ports.
// Assumes reset is held low from time zero over the first clock edge.
module sadc_capture_ctrl_chk #(
    parameter int DIV_W  = 8,
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DIV_W-1:0]  div_half,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic              sdata,
    input logic              conv,
    input logic              sck,
    input logic              busy,
    input logic [DATA_W-1:0] result,
    input logic              ref_ready,
    input logic              result_valid
);

    AST_PINS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(conv && sck)); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!conv && !sck)); // R6

    AST_BUSY_STARTS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (conv || sck)); // R6

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid); // R4

    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({ref_ready, result}) |-> result_valid); // R4

    AST_VALID_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (busy && !sck && !conv)); // R4

    AST_DIV_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(div_half)); // R2

endmodule

bind sadc_capture_ctrl sadc_capture_ctrl_chk #(.DIV_W(DIV_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/sadc_capture_ctrl_tb.sv
// Bench: sweeps the phase length, runs every command and checks pin
// timing, pulse counts and captured words against computed values.
module sadc_capture_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 8;
    localparam int DATA_W     = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DIV_W-1:0]  div_half = '0;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_op = 2'b00;
    logic              sdata = 1'b0;
    logic              conv, sck, busy, ref_ready, result_valid;
    logic [DATA_W-1:0] result;

    int          n_tests = 0;
    int          n_fail  = 0;
    bit          finished = 1'b0;
    int          pcount = 0;
    logic [12:0] tx_word = '0;
    logic [11:0] exp_res = '0;
    logic        exp_ref = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sadc_capture_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .div_half(div_half), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .sdata(sdata), .conv(conv), .sck(sck), .busy(busy),
        .result(result), .ref_ready(ref_ready), .result_valid(result_valid)
    );

    // Converter model: restart bit count on strobe, drive a bit per sck rise
    always @(posedge conv) pcount = 0;
    always @(posedge sck) begin
        pcount = pcount + 1;
        if (pcount >= 3 && pcount <= 15) sdata <= tx_word[15 - pcount];
        else sdata <= ~sdata;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!conv && !sck && !busy && !result_valid && !ref_ready && result == 0,
              "R1 reset state", {conv, sck, busy, result_valid, ref_ready}, 0);
        exp_res = '0;
        exp_ref = 1'b0;
    endtask

    // Issue one command, observe until idle, compare with computed shape
    task automatic run_cmd(input logic [1:0] op, input int poke, input logic [1:0] poke_op,
                           input bit want_valid);
        int L, idx, conv_hi, conv_r, sck_r, vcnt, vidx;
        int exp_busy, exp_chi, exp_cr, exp_sr;
        logic pc, ps;
        L = int'(div_half) + 1;
        case (op)
            2'b00: begin exp_busy = 34*L; exp_chi = L;   exp_cr = 1; exp_sr = 16; end
            2'b01: begin exp_busy = 4*L;  exp_chi = 2*L; exp_cr = 2; exp_sr = 0;  end
            2'b10: begin exp_busy = 8*L;  exp_chi = 4*L; exp_cr = 4; exp_sr = 0;  end
            default: begin exp_busy = 2*L; exp_chi = 0;  exp_cr = 0; exp_sr = 1;  end
        endcase
        cmd_valid = 1'b1; cmd_op = op;
        @(negedge clk);
        cmd_valid = 1'b0;
        idx = 0; conv_hi = 0; conv_r = 0; sck_r = 0; vcnt = 0; vidx = -1;
        pc = 1'b0; ps = 1'b0;
        check(busy && (conv == (op != 2'b11)) && (sck == (op == 2'b11)),
              "R6 busy with first edge", {busy, conv, sck}, 0);
        while (busy && idx < 4000) begin
            if (conv) conv_hi++;
            if (conv && !pc) conv_r++;
            if (sck && !ps) sck_r++;
            if (result_valid) begin vcnt++; vidx = idx; end
            pc = conv; ps = sck;
            if (idx == poke) begin cmd_valid = 1'b1; cmd_op = poke_op; end
            else cmd_valid = 1'b0;
            idx++;
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        check(idx == exp_busy, (poke >= 0) ? "R7 busy length with ignored request" : "R6 busy length",
              idx, exp_busy);
        check(conv_hi == exp_chi, (op == 2'b01) ? "R8 conv high cycles" :
              (op == 2'b10) ? "R9 conv high cycles" : "R2 conv high cycles", conv_hi, exp_chi);
        check(conv_r == exp_cr, (op == 2'b10) ? "R9 conv pulse count" : "R8 conv pulse count",
              conv_r, exp_cr);
        check(sck_r == exp_sr, (op == 2'b11) ? "R10 sck pulse count" : "R2 sck pulse count",
              sck_r, exp_sr);
        if (op == 2'b00) begin
            if (want_valid) begin
                exp_res = tx_word[11:0];
                exp_ref = tx_word[12];
                check(vcnt == 1, "R4 valid count", vcnt, 1);
                check(vidx == 33*L, "R4 valid position", vidx, 33*L);
            end else begin
                check(vcnt == 0, "R5 stale word dropped", vcnt, 0);
            end
        end else begin
            check(vcnt == 0, "R10 no valid on power command", vcnt, 0);
        end
        check(result == exp_res, (op == 2'b00) ? "R3 result word" : "R4 result held",
              int'(result), int'(exp_res));
        check(ref_ready == exp_ref, "R3 ref_ready bit", int'(ref_ready), int'(exp_ref));
        check(!conv && !sck, "R6 idle pins", {conv, sck}, 0);
    endtask

    initial begin
        logic [11:0] pats [4];
        pats[0] = 12'h000; pats[1] = 12'hFFF; pats[2] = 12'hA5A; pats[3] = 12'h5A5;
        for (int d = 0; d < 4; d++) begin
            @(negedge clk);
            div_half = DIV_W'(d);
            do_reset();
            tx_word = {1'b1, 12'hBAD};
            run_cmd(2'b00, -1, 2'b00, 1'b0);    // R5 first word stale
            check(result == 0 && !ref_ready, "R5 outputs stay zero", int'(result), 0);
            for (int p = 0; p < 4; p++) begin
                tx_word = {p[0], pats[p]};
                run_cmd(2'b00, -1, 2'b00, 1'b1);
            end
            for (int b = 0; b < 12; b++) begin
                tx_word = {b[0], 12'(1 << b)};
                run_cmd(2'b00, -1, 2'b00, 1'b1);  // R3 walking one
            end
            tx_word = {1'b0, 12'h3C7};
            run_cmd(2'b00, 5, 2'b01, 1'b1);     // R7 nap request mid-burst
            run_cmd(2'b01, -1, 2'b00, 1'b0);    // R8
            run_cmd(2'b11, -1, 2'b00, 1'b0);    // R10
            run_cmd(2'b10, 3, 2'b00, 1'b0);     // R9 with R7 poke
            run_cmd(2'b11, 1, 2'b10, 1'b0);     // R10 with R7 poke
            tx_word = {1'b1, 12'h812};
            run_cmd(2'b00, 33*(d+1), 2'b00, 1'b1); // R7 poke in valid cycle
        end
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule